// File: doc/BRIEF.md
# Omega Network Connection Set-up Controller

This block decides whether a circuit can be opened through an N x N omega network made of log2 N stages of 2x2 switches. Each stage has N/2 switches. Perfect-shuffle wiring joins consecutive stages. Each clock the block takes at most one command, either an open (source, destination) or a close (destination). It walks the path with destination-tag routing and tests every switch output link on that path against per-stage occupancy maps. It then answers with a result code one cycle later.

An open is accepted only if its source and destination ports are idle and no link on its path is taken. The block then records the source, the destination and all path links in one cycle. A close looks up the source stored for that destination, rebuilds the same path and frees it. The data path itself, switch queues and rearrangement belong to other blocks. The `LEAD_SHUFFLE` parameter sets whether the network inputs also pass through a shuffle before the first stage. With the default of 0, stage 0 sees the source position unchanged.

Top module: `omega_setup_ctrl`

## Requirements
- R1: Every command seen with `cmd_valid` high at a rising clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R2: Stage j (j = 0 is the first stage) is steered by destination bit IDX_W-1-j. Routing bit 0 selects the upper switch output (even link) and 1 selects the lower output (odd link). The stage-j output link is the stage input position with its LSB replaced by the routing bit. The input position of stage j>0 is the previous link rotated left by one bit. The last link always equals the destination.
- R3: An open with idle ports is granted (code 2'b00) only when every path link is free. All its links become occupied at the same clock edge, so the very next command already sees them.
- R4: An open that meets an occupied link at any stage returns code 2'b01 (blocked) and changes no state.
- R5: An open whose source or destination is already held returns code 2'b10 (busy) and changes no state. The busy check takes priority over the blocked check.
- R6: A close (`cmd_close`=1) of a held destination returns 2'b00. It frees that connection's links, its source and its destination, so the same path can be granted again.
- R7: A close of a destination that is not held returns 2'b11 and changes no state. A later command behaves as if the close never happened.
- R8: Synchronous active-high reset clears every occupancy map and port record and drops `rsp_valid`.
- R9: With N = 8 and the default wiring, while 101->011 is held, an open 100->001 is blocked (same first-stage link) and an open 100->110 is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_close | input | 1 | 0 = open a connection, 1 = close one |
| cmd_src | input | IDX_W | Source port of an open (ignored on close) |
| cmd_dst | input | IDX_W | Destination port |
| rsp_valid | output | 1 | Result present (one cycle after the command) |
| rsp_code | output | 2 | 00 done, 01 blocked, 10 busy, 11 not connected |

## Verification
The bench targets internal blocking at the first and at the middle stage. A router that used the wrong destination bit or skipped the shuffle rotation would grant those opens instead of blocking them. An open that is both busy and blocked tells whether busy really takes priority. Re-opening a path right after its close shows whether a release frees every stage or leaves stale links behind, and a double close shows whether an unheld close corrupts the tables. A reset in the middle of the run, followed by a close, shows whether any connection survives reset.

// File: rtl/omega_ctrl_pkg.sv
package omega_ctrl_pkg;

    typedef enum logic [1:0] {
        RSP_DONE    = 2'b00,
        RSP_BLOCKED = 2'b01,
        RSP_BUSY    = 2'b10,
        RSP_NOCONN  = 2'b11
    } rsp_code_e;

    typedef enum logic {
        CMD_OPEN  = 1'b0,
        CMD_CLOSE = 1'b1
    } cmd_kind_e;

    // outcome of one command, before registering
    typedef struct packed {
        logic      valid;
        rsp_code_e code;
    } rsp_t;

endpackage

// File: rtl/omega_path.sv
module omega_path #(
    parameter int N_PORTS      = 8,
    parameter bit LEAD_SHUFFLE = 1'b0,
    localparam int IDX_W       = $clog2(N_PORTS),
    localparam int STAGES      = IDX_W
) (
    input  logic [IDX_W-1:0]              src,
    input  logic [IDX_W-1:0]              dst,
    output logic [STAGES-1:0][IDX_W-1:0]  links
);

    genvar j;
    generate
        for (j = 0; j < STAGES; j++) begin : g_stage
            logic [IDX_W-1:0] pos_in;
            if (j == 0) begin : g_first
                if (LEAD_SHUFFLE) begin : g_shuf
                    assign pos_in = {src[IDX_W-2:0], src[IDX_W-1]};
                end else begin : g_direct
                    assign pos_in = src;
                end
            end else begin : g_next
                assign pos_in = {links[j-1][IDX_W-2:0], links[j-1][IDX_W-1]};
            end
            // switch number is pos_in[IDX_W-1:1]; routing bit picks upper/lower
            assign links[j] = {pos_in[IDX_W-1:1], dst[IDX_W-1-j]};
        end
    endgenerate

    // R2: destination-tag routing always lands on the requested output
    always_comb begin
        if (!$isunknown(dst) && !$isunknown(src)) begin
            a_r2_path_ends_at_dst: assert (links[STAGES-1] == dst)
                else $error("path does not end at destination");
        end
    end

endmodule

// File: rtl/omega_link_table.sv
module omega_link_table #(
    parameter int N_PORTS = 8,
    localparam int IDX_W  = $clog2(N_PORTS),
    localparam int STAGES = IDX_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [STAGES-1:0][IDX_W-1:0]  links,
    input  logic                          set_en,
    input  logic                          clr_en,
    output logic                          path_free
);

    logic [STAGES-1:0] hit;

    genvar j;
    generate
        for (j = 0; j < STAGES; j++) begin : g_map
            logic [N_PORTS-1:0] occ;

            always_ff @(posedge clk) begin
                if (rst) begin
                    occ <= '0;
                end else if (set_en) begin
                    occ[links[j]] <= 1'b1;
                end else if (clr_en) begin
                    occ[links[j]] <= 1'b0;
                end
            end

            assign hit[j] = occ[links[j]];

            // R3: a grant marks this stage's link by the next cycle
            a_r3_link_marked: assert property (@(posedge clk) disable iff (rst)
                set_en |=> occ[$past(links[j])])
                else $error("granted link not marked");

            // R3: never grant over an occupied link
            a_r3_grant_on_free: assert property (@(posedge clk) disable iff (rst)
                set_en |-> !occ[links[j]])
                else $error("grant over occupied link");

            // R6: a close only frees links that were held, and frees them
            a_r6_close_held: assert property (@(posedge clk) disable iff (rst)
                clr_en |-> occ[links[j]])
                else $error("closing a free link");

            a_r6_link_freed: assert property (@(posedge clk) disable iff (rst)
                clr_en |=> !occ[$past(links[j])])
                else $error("closed link still occupied");
        end
    endgenerate

    assign path_free = ~|hit;

endmodule

// File: rtl/omega_setup_ctrl.sv
module omega_setup_ctrl
    import omega_ctrl_pkg::*;
#(
    parameter int N_PORTS      = 8,
    parameter bit LEAD_SHUFFLE = 1'b0,
    localparam int IDX_W       = $clog2(N_PORTS),
    localparam int STAGES      = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_close,
    input  logic [IDX_W-1:0] cmd_src,
    input  logic [IDX_W-1:0] cmd_dst,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code
);

    logic [N_PORTS-1:0]            src_held;
    logic [N_PORTS-1:0]            dst_held;
    logic [N_PORTS-1:0][IDX_W-1:0] owner;

    logic [IDX_W-1:0]             path_src;
    logic [STAGES-1:0][IDX_W-1:0] links;
    logic                         path_free;
    logic                         set_en;
    logic                         clr_en;
    rsp_t                         rsp_d;
    rsp_t                         rsp_q;

    // a close rebuilds the path from the source recorded for its destination
    assign path_src = cmd_close ? owner[cmd_dst] : cmd_src;

    omega_path #(
        .N_PORTS      (N_PORTS),
        .LEAD_SHUFFLE (LEAD_SHUFFLE)
    ) u_path (
        .src   (path_src),
        .dst   (cmd_dst),
        .links (links)
    );

    omega_link_table #(
        .N_PORTS (N_PORTS)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .links     (links),
        .set_en    (set_en),
        .clr_en    (clr_en),
        .path_free (path_free)
    );

    always_comb begin
        set_en      = 1'b0;
        clr_en      = 1'b0;
        rsp_d.valid = cmd_valid;
        rsp_d.code  = RSP_DONE;
        if (cmd_close == CMD_CLOSE) begin
            if (!dst_held[cmd_dst]) begin
                rsp_d.code = RSP_NOCONN;
            end else begin
                clr_en = cmd_valid;
            end
        end else begin
            if (src_held[cmd_src] || dst_held[cmd_dst]) begin
                rsp_d.code = RSP_BUSY;
            end else if (!path_free) begin
                rsp_d.code = RSP_BLOCKED;
            end else begin
                set_en = cmd_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_held <= '0;
            dst_held <= '0;
            owner    <= '0;
            rsp_q    <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (set_en) begin
                src_held[cmd_src] <= 1'b1;
                dst_held[cmd_dst] <= 1'b1;
                owner[cmd_dst]    <= cmd_src;
            end else if (clr_en) begin
                src_held[owner[cmd_dst]] <= 1'b0;
                dst_held[cmd_dst]        <= 1'b0;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;

    // R1: one response per command, one cycle later
    a_r1_rsp_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid)
        else $error("missing response");

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid)
        else $error("response without command");

    // R4: a blocked open leaves the port records untouched
    a_r4_blocked_no_change: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_close && !path_free) |=> ($stable(src_held) && $stable(dst_held)))
        else $error("blocked open changed state");

    // R5: opens on a held port are refused
    a_r5_busy_refused: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_close && (src_held[cmd_src] || dst_held[cmd_dst]))
            |=> (rsp_code == RSP_BUSY))
        else $error("held port not reported busy");

    // R7: closing an unheld destination changes nothing
    a_r7_noconn_no_change: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_close && !dst_held[cmd_dst])
            |=> ($stable(src_held) && $stable(dst_held) && rsp_code == RSP_NOCONN))
        else $error("unheld close changed state");

endmodule

// File: tb/sim_omega_setup_ctrl.sv
`timescale 1ns/1ps
module sim_omega_setup_ctrl;

    localparam int N_PORTS = 8;
    localparam int IDX_W   = 3;
    localparam int NVEC    = 17;

    // {close, src[2:0], dst[2:0], expected code[1:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_101_011_00,  //  0 R9 open 101->011
        9'b0_100_001_01,  //  1 R9 R4 shares first-stage link -> blocked
        9'b0_100_110_00,  //  2 R9 disjoint path -> granted
        9'b0_101_000_10,  //  3 R5 source held
        9'b0_000_011_10,  //  4 R5 destination held
        9'b1_000_010_11,  //  5 R7 close of unheld destination
        9'b1_000_011_00,  //  6 R6 close 101->011
        9'b0_101_011_00,  //  7 R6 same path granted again
        9'b0_100_001_10,  //  8 R5 busy and blocked -> busy wins
        9'b1_000_110_00,  //  9 R6
        9'b1_000_011_00,  // 10 R6
        9'b0_100_001_00,  // 11 R3 links now free
        9'b0_000_000_01,  // 12 R3 R4 middle-stage conflict
        9'b0_111_111_00,  // 13 R3 disjoint path
        9'b1_000_001_00,  // 14 R6
        9'b0_000_000_00,  // 15 R6 freed middle link reusable
        9'b1_000_001_11   // 16 R7 double close
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_close = 1'b0;
    logic [IDX_W-1:0] cmd_src = '0;
    logic [IDX_W-1:0] cmd_dst = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    omega_setup_ctrl #(.N_PORTS(N_PORTS)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_close (cmd_close),
        .cmd_src   (cmd_src),
        .cmd_dst   (cmd_dst),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // drive at a falling edge, response sampled at the next falling edge
    task automatic issue(input logic cl, input logic [2:0] s, input logic [2:0] d,
                         input logic [1:0] exp, input string req);
        cmd_valid = 1'b1;
        cmd_close = cl;
        cmd_src   = s;
        cmd_dst   = d;
        @(negedge clk);
        check(req, {rsp_valid, rsp_code}, {1'b1, exp});
    endtask

    task automatic idle(input string req);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(req, {rsp_valid, 2'b00}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset response low", {rsp_valid, 2'b00}, 3'b000);
        rst = 1'b0;
        idle("R1 idle cycle no response");

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][8], VEC[i][7:5], VEC[i][4:2], VEC[i][1:0],
                  $sformatf("R3/R9 vector %0d", i));
        end
        idle("R1 response drops after command");

        // held now: 111->111 and 000->000
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(1'b1, 3'b000, 3'b111, 2'b11, "R8 close after reset finds nothing");
        issue(1'b0, 3'b000, 3'b000, 2'b00, "R8 ports free after reset");
        issue(1'b0, 3'b001, 3'b001, 2'b01, "R4 first-stage clash with 000->000");
        issue(1'b1, 3'b000, 3'b000, 2'b00, "R6 close after blocked attempt");
        issue(1'b0, 3'b001, 3'b001, 2'b00, "R4 blocked attempt left no trace");
        idle("R1 final idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule